// File: doc/BRIEF.md
# I2C Bus Condition Control Register

This block is the 8-bit control and status register that sits between a CPU register bus and the line logic of an I2C master. Software writes it to ask for a START or a STOP condition. A small sequencer then produces the condition on the SDA and SCL output enables, with each phase lasting a set number of clock cycles. Read back, the same register shows whether the bus is occupied. Busy tracking watches synchronised copies of the SDA and SCL lines, so it also sees conditions that other masters create.

Software can also set the SDA output level by hand, read the live SCL level, and pulse a soft reset that frees a hung protocol control block. The soft reset does not touch the stored data-output level. Two fields are each guarded by a companion protect bit, which must be written as 0 in the same write for the update to take effect. A START made by hand through the data bit never moves the block into the transfer-enabled state. Only a START made through the bus-busy bit does that.

Output enables are active high: a 1 pulls the open-drain line low. The byte shift engine, acknowledge handling and pad drivers lie outside this block.

Top module: `i2c_bus_cond_reg`

## Requirements
- R1: After reset, rd_data reads 0x7D. Bits 6, 4, 2 and 0 always read 1, and bit 1 always reads 0.
- R2: Bit 7 (bus busy) reads 1 once the synchronised SDA falls while synchronised SCL is high. It reads 0 once SDA rises while SCL is high.
- R3: A write with bit 6 = 0 requests a START when bit 7 = 1 and a STOP when bit 7 = 0. A write with bit 6 = 1 requests nothing.
- R4: A START holds sda_oe=1 with scl_oe=0 for HOLD_CYCLES cycles, then both at 1 for HOLD_CYCLES cycles. After that, xfer_enable=1 and SCL stays held low.
- R5: A STOP holds sda_oe=1 and scl_oe=1 for HOLD_CYCLES cycles, then sda_oe=1 and scl_oe=0 for HOLD_CYCLES cycles, then both at 0 for HOLD_CYCLES cycles. After that, xfer_enable=0 and both lines are released.
- R6: A write with bit 4 = 0 sets the SDA output level to bit 5 (sda_oe = not bit 5) in the next cycle. With bit 4 = 1 the level is unchanged. Bit 5 reads the current output level, not sda_oe.
- R7: Data-bit writes are ignored while xfer_active=1 or while a START or STOP sequence runs.
- R8: A START made by driving SDA low through bit 5 sets the busy bit but leaves xfer_enable at 0.
- R9: With SCL held low after a START, releasing SDA through bit 5 creates no STOP and busy stays 1. A STOP requested through bit 7 still releases the bus.
- R10: Bit 3 reads the synchronised SCL level: 0 for low and 1 for high.
- R11: A write with bit 1 = 1 pulses ctl_reset for one cycle, aborts any sequence, and clears busy and xfer_enable. The data-output level is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| sda_in | input | 1 | SDA line sample (asynchronous) |
| scl_in | input | 1 | SCL line sample (asynchronous) |
| xfer_active | input | 1 | Shift engine is moving a byte |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_oe | output | 1 | Pull SCL low when 1 |
| xfer_enable | output | 1 | Transfer-enabled state reached through a requested START |
| ctl_reset | output | 1 | One-cycle reset pulse to the protocol control block |

## Verification
The embedded assertions check on every cycle the following:
- busy is set after a detected START edge and cleared after a detected STOP edge;
- a protected write never starts a sequence;
- a protected write, or a write during a transfer, leaves the data level unchanged;
- xfer_enable only rises right after a completed START sequence;
- the soft reset clears the busy and transfer state.

The phase-by-phase timing of START and STOP needs the bench's scenarios, which sample the output enables cycle by cycle. The same holds for the absence of a STOP when SDA is released by hand under a held-low SCL, for the read-back layout, and for the interplay between random data-bit writes and bus-line activity.

// File: rtl/i2c_cond_pkg.sv
`timescale 1ns/1ps
package i2c_cond_pkg;

    // Read/write bit positions; the layout is visible to software.
    localparam int unsigned BIT_BUSY    = 7;
    localparam int unsigned BIT_CPROT   = 6;
    localparam int unsigned BIT_DLEVEL  = 5;
    localparam int unsigned BIT_DPROT   = 4;
    localparam int unsigned BIT_SCLMON  = 3;
    localparam int unsigned BIT_SOFTRST = 1;

    typedef enum logic [2:0] {
        G_IDLE,
        G_S_SDA,   // start: SDA low, SCL released
        G_S_SCL,   // start: both low
        G_P_SDA,   // stop: SDA low, SCL low
        G_P_SCL,   // stop: SDA low, SCL released
        G_P_REL    // stop: both released
    } gen_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_cond_gen.sv
`timescale 1ns/1ps
module i2c_cond_gen
    import i2c_cond_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic req_start,
    input  logic req_stop,
    output logic gen_idle,
    output logic sda_low,
    output logic scl_low,
    output logic start_done,
    output logic stop_done
);
    localparam int unsigned CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        gen_state_e    st;
        logic [CW-1:0] cnt;
    } gen_t;

    gen_t g_d, g_q;
    logic last;

    always_comb begin
        g_d        = g_q;
        start_done = 1'b0;
        stop_done  = 1'b0;
        last       = (g_q.cnt == LAST);
        if (g_q.st != G_IDLE) g_d.cnt = g_q.cnt + 1'b1;
        case (g_q.st)
            G_IDLE: begin
                g_d.cnt = '0;
                if (req_start)     g_d.st = G_S_SDA;
                else if (req_stop) g_d.st = G_P_SDA;
            end
            G_S_SDA: if (last) begin g_d.st = G_S_SCL; g_d.cnt = '0; end
            G_S_SCL: if (last) begin g_d.st = G_IDLE;  g_d.cnt = '0; start_done = 1'b1; end
            G_P_SDA: if (last) begin g_d.st = G_P_SCL; g_d.cnt = '0; end
            G_P_SCL: if (last) begin g_d.st = G_P_REL; g_d.cnt = '0; end
            G_P_REL: if (last) begin g_d.st = G_IDLE;  g_d.cnt = '0; stop_done = 1'b1; end
            default: begin g_d.st = G_IDLE; g_d.cnt = '0; end
        endcase
        if (soft_rst) begin
            g_d.st     = G_IDLE;
            g_d.cnt    = '0;
            start_done = 1'b0;
            stop_done  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{st: G_IDLE, cnt: '0};
        else        g_q <= g_d;
    end

    assign gen_idle = (g_q.st == G_IDLE);
    assign sda_low  = (g_q.st == G_S_SDA) || (g_q.st == G_S_SCL) ||
                      (g_q.st == G_P_SDA) || (g_q.st == G_P_SCL);
    assign scl_low  = (g_q.st == G_S_SCL) || (g_q.st == G_P_SDA);

    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_done && stop_done)); // R4
    AST_START_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.st == G_S_SDA && last && !soft_rst) |=> (g_q.st == G_S_SCL)); // R4
    AST_STOP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.st == G_P_SCL && last && !soft_rst) |=> (g_q.st == G_P_REL)); // R5
endmodule

// File: rtl/i2c_bus_cond_reg.sv
`timescale 1ns/1ps
module i2c_bus_cond_reg
    import i2c_cond_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       sda_in,
    input  logic       scl_in,
    input  logic       xfer_active,
    output logic       sda_oe,
    output logic       scl_oe,
    output logic       xfer_enable,
    output logic       ctl_reset
);
    typedef struct packed {
        logic busy;
        logic dout;
        logic xfer_en;
        logic ctl_rst;
        logic sda_prev;
    } reg_t;

    reg_t r_d, r_q;

    logic sda_s, scl_s;
    logic soft_rst, req_start, req_stop;
    logic gen_idle, gen_sda_low, gen_scl_low, start_done, stop_done;
    logic start_det, stop_det, dout_wr;

    i2c_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sda_in), .sync_out(sda_s));
    i2c_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .async_in(scl_in), .sync_out(scl_s));

    always_comb begin
        soft_rst  = wr_en && wr_data[BIT_SOFTRST];
        req_start = wr_en && !wr_data[BIT_CPROT] &&  wr_data[BIT_BUSY] && gen_idle && !soft_rst;
        req_stop  = wr_en && !wr_data[BIT_CPROT] && !wr_data[BIT_BUSY] && gen_idle && !soft_rst;
        dout_wr   = wr_en && !wr_data[BIT_DPROT] && !xfer_active && gen_idle;
    end

    i2c_cond_gen #(.HOLD_CYCLES(HOLD_CYCLES)) u_gen (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .req_start(req_start), .req_stop(req_stop),
        .gen_idle(gen_idle), .sda_low(gen_sda_low), .scl_low(gen_scl_low),
        .start_done(start_done), .stop_done(stop_done));

    always_comb begin
        start_det = r_q.sda_prev && !sda_s && scl_s;
        stop_det  = !r_q.sda_prev && sda_s && scl_s;

        r_d          = r_q;
        r_d.sda_prev = sda_s;
        r_d.ctl_rst  = soft_rst;

        if (start_det)     r_d.busy = 1'b1;
        else if (stop_det) r_d.busy = 1'b0;

        if (dout_wr)         r_d.dout = wr_data[BIT_DLEVEL];
        else if (start_done) r_d.dout = 1'b0;
        else if (stop_done)  r_d.dout = 1'b1;

        if (start_done)     r_d.xfer_en = 1'b1;
        else if (stop_done) r_d.xfer_en = 1'b0;

        if (soft_rst) begin
            r_d.busy    = 1'b0;
            r_d.xfer_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{busy: 1'b0, dout: 1'b1, xfer_en: 1'b0, ctl_rst: 1'b0, sda_prev: 1'b1};
        else        r_q <= r_d;
    end

    assign sda_oe      = gen_sda_low || (gen_idle && !r_q.dout);
    assign scl_oe      = gen_scl_low || (gen_idle && r_q.xfer_en);
    assign xfer_enable = r_q.xfer_en;
    assign ctl_reset   = r_q.ctl_rst;
    assign rd_data     = {r_q.busy, 1'b1, !sda_oe, 1'b1, scl_s, 1'b1, 1'b0, 1'b1};

    AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !soft_rst) |=> r_q.busy); // R2
    AST_BUSY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det && !soft_rst) |=> !r_q.busy); // R2
    AST_REQ_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_CPROT] && gen_idle) |=> gen_idle); // R3
    AST_DOUT_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_DPROT] && gen_idle) |=> $stable(r_q.dout)); // R6
    AST_DOUT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && gen_idle) |=> $stable(r_q.dout)); // R7
    AST_XFER_ONLY_GEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.xfer_en) |-> $past(start_done)); // R8
    AST_SOFT_RST: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!r_q.busy && !r_q.xfer_en && ctl_reset && gen_idle)); // R11
endmodule

// File: tb/i2c_bus_cond_reg_tb_top.sv
`timescale 1ns/1ps
module i2c_bus_cond_reg_tb_top;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'hFD;
    logic [7:0] rd_data;
    logic       xfer_active = 1'b0;
    logic       sda_oe, scl_oe, xfer_enable, ctl_reset;
    logic       ext_sda_low = 1'b0, ext_scl_low = 1'b0;
    logic       sda_line, scl_line;
    int         n_checks = 0, n_errors = 0;
    logic       exp_dout;

    always #2 clk = ~clk;

    assign sda_line = !(sda_oe || ext_sda_low);
    assign scl_line = !(scl_oe || ext_scl_low);

    i2c_bus_cond_reg #(.HOLD_CYCLES(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sda_in(sda_line), .scl_in(scl_line),
        .xfer_active(xfer_active), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .xfer_enable(xfer_enable), .ctl_reset(ctl_reset));

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'hFD;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Expected START phase outputs {sda_oe, scl_oe} at sample k after the write edge.
    function automatic logic [1:0] start_phase(input int k);
        return (k < HOLD) ? 2'b10 : 2'b11;
    endfunction
    function automatic logic [1:0] stop_phase(input int k);
        if (k < HOLD)     return 2'b11;
        if (k < 2 * HOLD) return 2'b10;
        return 2'b00;
    endfunction

    task automatic do_start;
        wr(8'hBD);
        for (int k = 0; k < 2 * HOLD; k++) begin
            check("R4 start phase", {sda_oe, scl_oe}, start_phase(k));
            @(negedge clk);
        end
    endtask

    initial begin
        #400000;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1C2B));
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check("R1 reset read", rd_data, 8'h7D);
        check("R1 reset oe", {sda_oe, scl_oe, xfer_enable, ctl_reset}, 4'b0000);

        // R10 SCL monitor
        ext_scl_low = 1'b1; idle(4);
        check("R10 scl low", rd_data[3], 0);
        ext_scl_low = 1'b0; idle(4);
        check("R10 scl high", rd_data[3], 1);

        // R6 R7 R8 random data-bit writes
        exp_dout = 1'b1;
        for (int i = 0; i < 40; i++) begin
            logic lvl, prot, xa;
            lvl = 1'($urandom); prot = 1'($urandom); xa = 1'($urandom);
            xfer_active = xa;
            wr({2'b11, lvl, prot, 4'b1101});
            xfer_active = 1'b0;
            if (!prot && !xa) exp_dout = lvl;
            check("R6 R7 sda level", sda_oe, !exp_dout);
            idle(5);
            check("R6 level readback", rd_data[5], exp_dout);
            check("R8 manual start busy", rd_data[7], !exp_dout);
            check("R8 no xfer", xfer_enable, 0);
            check("R1 fixed bits", {rd_data[6], rd_data[4], rd_data[2:0]}, 5'b11101);
        end
        wr(8'hED); idle(5);
        check("R2 released", rd_data[7], 0);

        // R3 protected request
        wr(8'hFD);
        check("R3 protected", {sda_oe, scl_oe}, 2'b00);
        idle(2 * HOLD);
        check("R3 no busy", {rd_data[7], xfer_enable}, 2'b00);

        // R4 START
        do_start;
        check("R4 after start", {sda_oe, scl_oe, xfer_enable}, 3'b111);
        idle(3);
        check("R2 busy after start", rd_data[7], 1);
        check("R6 readback low", rd_data[5], 0);

        // R7 ignored during transfer
        xfer_active = 1'b1; wr(8'hED); xfer_active = 1'b0;
        check("R7 xfer ignore", sda_oe, 1);

        // R9 manual release under held SCL
        wr(8'hED); idle(5);
        check("R9 sda released", {sda_oe, scl_oe}, 2'b01);
        check("R9 no stop", rd_data[7], 1);

        // R5 STOP via bus-busy bit
        wr(8'h3D);
        for (int k = 0; k < 3 * HOLD; k++) begin
            check("R5 stop phase", {sda_oe, scl_oe}, stop_phase(k));
            @(negedge clk);
        end
        check("R5 after stop", {sda_oe, scl_oe, xfer_enable}, 3'b000);
        idle(4);
        check("R2 busy cleared", rd_data[7], 0);

        // R11 soft reset after a START
        do_start;
        idle(3);
        wr(8'h7F);
        check("R11 pulse", ctl_reset, 1);
        check("R11 state", {xfer_enable, scl_oe, rd_data[7]}, 3'b000);
        check("R11 dout kept", sda_oe, 1);
        @(negedge clk);
        check("R11 pulse ends", ctl_reset, 0);
        idle(4);
        check("R11 busy stays clear", rd_data[7], 0);

        // R11 abort a running START
        wr(8'hBD); idle(1);
        wr(8'hFF);
        check("R11 abort", {scl_oe, xfer_enable}, 2'b00);
        idle(2 * HOLD);
        check("R11 abort no xfer", xfer_enable, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule